// File: doc/BRIEF.md
# Segment access permission checker

This block decides whether a single data access may proceed under the segment descriptor a processor holds in its cache. Each request carries the processor mode, the cached descriptor fields (valid, present, type, D/B, scaled limit), a flag marking the stack segment, and the access itself: offset, length and kind. The block applies the mode's rules. In 64-bit mode it checks only that the offset is canonical. In protected mode it checks the descriptor state, the type's access rights and the limit. In real mode it checks the limit alone. It answers one cycle later with a pass or fault verdict and a fault class.

With a passing verdict the block can also report read-ok or write-ok fast-path hints. An address-generation stage may cache these hints and skip the full check on later accesses through the same descriptor. Requests arrive on a valid/ready channel, and responses leave on one. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A response is consumed on an edge where `rsp_valid` and `rsp_ready` are both high. While a response waits unconsumed, the block holds it unchanged and accepts nothing new.

Top module: `seg_access_checker`

## Requirements
- R1: In 64-bit mode (mode code 2'b10) only the offset is examined. The access passes when bits 63 down to 47 are all equal. Otherwise it faults with class general-protection (code 0). A passing access sets the fast-path hint.
- R2: In protected mode (mode code 2'b01), a descriptor whose valid bit is clear faults as general-protection, even for the stack segment. This check takes priority over every other check.
- R3: In protected mode, a valid descriptor that is not present faults with the segment's own class: stack fault (code 1) for the stack segment, general-protection (code 0) otherwise.
- R4: Write (kind 2'b01) and read-modify-write (kind 2'b10) accesses are permitted only on types 2, 3, 6 and 7. Any other type gives the segment's own fault class.
- R5: Read accesses (kind 2'b00) fault with the segment's own class on types 8, 9, 12 and 13. All other types are readable.
- R6: On an expand-up segment, with length L = 1, 2, 4 or 8 bytes for length code 0 to 3, the access faults when L-1 exceeds the limit or when the offset exceeds limit-L+1. The arithmetic is 33-bit, so a small limit never wraps, and a limit of 0xFFFFFFFF admits a 4-byte access at 0xFFFFFFFC.
- R7: On an expand-down segment (types 4 to 7), the upper bound is 0xFFFFFFFF when D/B is set and 0xFFFF when it is clear. The access faults in any of three cases: the offset is at or below the limit, the offset is above the bound, or the bound minus the offset is less than L-1.
- R8: In real mode (mode code 2'b00, with 2'b11 treated the same), only the R6 limit rule applies. Valid, present and type are ignored. A violation gives a stack fault on the stack segment and general-protection otherwise.
- R9: The fast-path hint is read-ok for reads and write-ok for writes and read-modify-writes. It is set only on a passing access to an expand-up segment whose limit is at least 7, or on a passing 64-bit-mode access. It is never set on a fault or on an expand-down segment, and the two hints are never both set.
- R10: A response appears on the cycle after its request is accepted. `req_ready` is high whenever no response is waiting or the waiting one is being consumed. A stalled response holds all its fields stable. Each accepted request yields exactly one response, in order.
- R11: After reset no response is pending and the block is ready to accept a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 2 | 00 real, 01 protected, 10 64-bit |
| req_kind | input | 2 | 00 read, 01 write, 10 read-modify-write |
| req_len | input | 2 | Length code: 1, 2, 4 or 8 bytes |
| req_offset | input | OFS_W | Effective offset within the segment |
| desc_valid | input | 1 | Cached descriptor is valid |
| desc_present | input | 1 | Segment present bit |
| desc_type | input | 4 | Segment type field |
| desc_db | input | 1 | Default/big bit, picks expand-down upper bound |
| desc_limit | input | LIM_W | Scaled segment limit |
| seg_is_stack | input | 1 | Access goes through the stack segment |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Access refused |
| rsp_code | output | 1 | 0 general-protection, 1 stack fault |
| rsp_rd_ok | output | 1 | Read fast-path hint |
| rsp_wr_ok | output | 1 | Write fast-path hint |

## Verification
Some rules are checked on every cycle by the assertions. These cover the handshake: one response per accepted request, and fields held stable during a stall. They also cover hint exclusivity, the general-protection class for invalid descriptors and for 64-bit mode, the rule that write rights imply read rights, and the 0xFFFF ceiling on small expand-down segments. Other behaviours need chosen stimulus to show. The bench's scenarios cover the exact limit boundaries at both edges, the 33-bit no-wrap cases, the priority among valid, present, rights and limit, the stack-versus-general split in real and protected mode, and the hint rules across every type and access kind.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2
  } cpu_mode_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RMW   = 2'd2
  } acc_kind_e;

  typedef enum logic {
    FLT_GP = 1'b0,
    FLT_SS = 1'b1
  } flt_code_e;

  typedef struct packed {
    logic      fault;
    flt_code_e code;
    logic      rd_ok;
    logic      wr_ok;
  } chk_res_t;
endpackage

// File: rtl/seg_chk_rights.sv
// Decodes the 4-bit segment type into access rights and limit direction.
module seg_chk_rights (
  input  logic [3:0] seg_type,
  output logic       can_read,
  output logic       can_write,
  output logic       exp_down
);
  logic is_code;

  always_comb begin
    is_code   = seg_type[3];
    can_write = !is_code && seg_type[1];
    can_read  = !is_code || seg_type[1];
    exp_down  = !is_code && seg_type[2];
  end

  // R4
  always_comb begin
    if (!$isunknown(seg_type) && can_write)
      write_implies_read_chk: assert (can_read);
  end
endmodule

// File: rtl/seg_chk_limit.sv
// Expand-up and expand-down limit checks, done one bit wider than the limit.
module seg_chk_limit #(
  parameter int OFS_W   = 64,
  parameter int LIM_W   = 32,
  parameter int SMALL_W = 16
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [LIM_W-1:0] limit,
  input  logic [1:0]       len_sel,
  input  logic             db,
  output logic             up_fail,
  output logic             dn_fail
);
  localparam int EW = LIM_W + 1;

  logic [EW-1:0] len_m1, lim_e, up_room, ub_e, off_e;
  logic          off_hi_zero;

  always_comb begin
    len_m1      = (EW'(1) << len_sel) - EW'(1);
    lim_e       = {1'b0, limit};
    up_room     = lim_e - len_m1;
    off_e       = offset[EW-1:0];
    off_hi_zero = (offset[OFS_W-1:EW] == '0);
    ub_e        = db ? {1'b0, {LIM_W{1'b1}}} : EW'({SMALL_W{1'b1}});
    up_fail     = (len_m1 > lim_e) || !off_hi_zero || (off_e > up_room);
    dn_fail     = !off_hi_zero || (off_e <= lim_e) || (off_e > ub_e) ||
                  ((ub_e - off_e) < len_m1);
  end

  // R7
  always_comb begin
    if (!$isunknown({offset, limit, len_sel, db}) && !dn_fail && !db)
      small_ed_ceiling_chk: assert (offset <= OFS_W'({SMALL_W{1'b1}}));
  end
endmodule

// File: rtl/seg_chk_canon.sv
// Canonical-form test: all bits from the top down to CANON_BITS-1 equal.
module seg_chk_canon #(
  parameter int OFS_W      = 64,
  parameter int CANON_BITS = 48
) (
  input  logic [OFS_W-1:0] offset,
  output logic             is_canon
);
  localparam int TOP_W = OFS_W - CANON_BITS + 1;

  logic [TOP_W-1:0] top_bits;

  always_comb begin
    top_bits = offset[OFS_W-1:CANON_BITS-1];
    is_canon = (&top_bits) || (~|top_bits);
  end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker #(
  parameter int OFS_W      = 64,
  parameter int LIM_W      = 32,
  parameter int CANON_BITS = 48,
  parameter int SMALL_W    = 16,
  parameter int FAST_MIN   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_mode,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_len,
  input  logic [OFS_W-1:0] req_offset,
  input  logic             desc_valid,
  input  logic             desc_present,
  input  logic [3:0]       desc_type,
  input  logic             desc_db,
  input  logic [LIM_W-1:0] desc_limit,
  input  logic             seg_is_stack,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic             rsp_code,
  output logic             rsp_rd_ok,
  output logic             rsp_wr_ok
);
  import seg_chk_pkg::*;

  localparam logic [LIM_W-1:0] FAST_LIM = LIM_W'(FAST_MIN);

  logic      can_read, can_write, exp_down;
  logic      up_fail, dn_fail, is_canon;
  logic      is_wr, fast_lim, accept;
  flt_code_e seg_code;
  cpu_mode_e mode;
  chk_res_t  res_d, res_q;

  seg_chk_rights u_rights (
    .seg_type (desc_type),
    .can_read (can_read),
    .can_write(can_write),
    .exp_down (exp_down)
  );

  seg_chk_limit #(.OFS_W(OFS_W), .LIM_W(LIM_W), .SMALL_W(SMALL_W)) u_limit (
    .offset (req_offset),
    .limit  (desc_limit),
    .len_sel(req_len),
    .db     (desc_db),
    .up_fail(up_fail),
    .dn_fail(dn_fail)
  );

  seg_chk_canon #(.OFS_W(OFS_W), .CANON_BITS(CANON_BITS)) u_canon (
    .offset  (req_offset),
    .is_canon(is_canon)
  );

  always_comb begin
    mode     = cpu_mode_e'(req_mode);
    is_wr    = (acc_kind_e'(req_kind) != ACC_READ);
    seg_code = seg_is_stack ? FLT_SS : FLT_GP;
    fast_lim = (desc_limit >= FAST_LIM);
    res_d    = '0;
    case (mode)
      MODE_LONG: begin
        if (!is_canon) begin
          res_d.fault = 1'b1;
          res_d.code  = FLT_GP;
        end else begin
          res_d.rd_ok = !is_wr;
          res_d.wr_ok = is_wr;
        end
      end
      MODE_PROT: begin
        if (!desc_valid) begin
          res_d.fault = 1'b1;
          res_d.code  = FLT_GP;
        end else if (!desc_present) begin
          res_d.fault = 1'b1;
          res_d.code  = seg_code;
        end else if (is_wr ? !can_write : !can_read) begin
          res_d.fault = 1'b1;
          res_d.code  = seg_code;
        end else if (exp_down ? dn_fail : up_fail) begin
          res_d.fault = 1'b1;
          res_d.code  = seg_code;
        end else if (!exp_down && fast_lim) begin
          res_d.rd_ok = !is_wr;
          res_d.wr_ok = is_wr;
        end
      end
      default: begin
        if (up_fail) begin
          res_d.fault = 1'b1;
          res_d.code  = seg_code;
        end else if (fast_lim) begin
          res_d.rd_ok = !is_wr;
          res_d.wr_ok = is_wr;
        end
      end
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (accept)    res_q     <= res_d;
    end
  end

  assign rsp_fault = res_q.fault;
  assign rsp_code  = res_q.code;
  assign rsp_rd_ok = res_q.rd_ok;
  assign rsp_wr_ok = res_q.wr_ok;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid &&
      $stable({rsp_fault, rsp_code, rsp_rd_ok, rsp_wr_ok}));

  // R10
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R1
  long_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode == 2'b10 |=> rsp_code == 1'b0);

  // R2
  invalid_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_mode == 2'b01 && !desc_valid
      |=> rsp_fault && rsp_code == 1'b0);

  // R9
  hint_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_rd_ok, rsp_wr_ok}) &&
      !(rsp_fault && (rsp_rd_ok || rsp_wr_ok)));
endmodule

// File: tb/seg_access_checker_bench.sv
`timescale 1ns/1ps
module seg_access_checker_bench;
  localparam int OFS_W = 64;
  localparam int LIM_W = 32;

  typedef struct {
    logic [3:0] val;
    string      tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_mode = '0, req_kind = '0, req_len = '0;
  logic [OFS_W-1:0] req_offset = '0;
  logic             desc_valid = 1'b0, desc_present = 1'b0, desc_db = 1'b0;
  logic [3:0]       desc_type = '0;
  logic [LIM_W-1:0] desc_limit = '0;
  logic             seg_is_stack = 1'b0;
  logic             rsp_valid, rsp_ready = 1'b1;
  logic             rsp_fault, rsp_code, rsp_rd_ok, rsp_wr_ok;

  int   checks = 0, errors = 0, sent = 0, got = 0, cyc = 0;
  bit   bp_on = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  seg_access_checker u_seg_access_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_kind(req_kind), .req_len(req_len),
    .req_offset(req_offset), .desc_valid(desc_valid),
    .desc_present(desc_present), .desc_type(desc_type), .desc_db(desc_db),
    .desc_limit(desc_limit), .seg_is_stack(seg_is_stack),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_code(rsp_code), .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
  );

  // Expected {fault, code, rd_ok, wr_ok} from the requirements.
  function automatic logic [3:0] model(logic [1:0] m, logic [1:0] k,
      logic [1:0] l, logic [63:0] off, logic v, logic p, logic [3:0] t,
      logic db, logic [31:0] lim, logic stk);
    logic [63:0] lm1, lim64, ub;
    logic        w, upf, dnf, ed, rd, wr, fast;
    logic [16:0] top;
    lm1   = (64'd1 << l) - 64'd1;
    lim64 = {32'd0, lim};
    w     = (k != 2'b00);
    upf   = (lm1 > lim64) || (off > lim64 - lm1);
    ub    = db ? 64'hFFFF_FFFF : 64'hFFFF;
    dnf   = (off <= lim64) || (off > ub) || ((ub - off) < lm1);
    ed    = (t == 4) || (t == 5) || (t == 6) || (t == 7);
    wr    = (t == 2) || (t == 3) || (t == 6) || (t == 7);
    rd    = !((t == 8) || (t == 9) || (t == 12) || (t == 13));
    fast  = (lim >= 32'd7);
    top   = off[63:47];
    if (m == 2'b10) begin
      if (!(top == 17'h0 || top == 17'h1FFFF)) return 4'b1000;
      return {2'b00, !w, w};
    end
    if (m == 2'b01) begin
      if (!v) return 4'b1000;
      if (!p) return {1'b1, stk, 2'b00};
      if (w ? !wr : !rd) return {1'b1, stk, 2'b00};
      if (ed ? dnf : upf) return {1'b1, stk, 2'b00};
      if (!ed && fast) return {2'b00, !w, w};
      return 4'b0000;
    end
    if (upf) return {1'b1, stk, 2'b00};
    if (fast) return {2'b00, !w, w};
    return 4'b0000;
  endfunction

  task automatic send(string tag, logic [1:0] m, logic [1:0] k, logic [1:0] l,
      logic [63:0] off, logic v, logic p, logic [3:0] t, logic db,
      logic [31:0] lim, logic stk);
    exp_t e;
    e.val = model(m, k, l, off, v, p, t, db, lim, stk);
    e.tag = tag;
    req_mode = m; req_kind = k; req_len = l; req_offset = off;
    desc_valid = v; desc_present = p; desc_type = t; desc_db = db;
    desc_limit = lim; seg_is_stack = stk; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    sb.push_back(e);
    sent++;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Back-pressure pattern on the response channel.
  always @(posedge clk) begin
    #1;
    cyc++;
    rsp_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
  end

  // Monitor: compare each consumed response; check stall stability.
  logic       prev_stall = 1'b0;
  logic [3:0] prev_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!rsp_valid || {rsp_fault, rsp_code, rsp_rd_ok, rsp_wr_ok} != prev_val) begin
          errors++;
          $display("FAIL R10 stall hold: got valid=%0b val=%b exp valid=1 val=%b",
                   rsp_valid, {rsp_fault, rsp_code, rsp_rd_ok, rsp_wr_ok}, prev_val);
        end
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_val   = {rsp_fault, rsp_code, rsp_rd_ok, rsp_wr_ok};
      if (rsp_valid && rsp_ready) begin
        got++;
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected response: got val=%b exp none", prev_val);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (prev_val !== e.val) begin
            errors++;
            $display("FAIL %s: got %b exp %b", e.tag, prev_val, e.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 reset: got valid=%b ready=%b exp 0 1", rsp_valid, req_ready);
    end
    @(posedge clk); #1;

    // R1 64-bit mode canonical
    send("R1 canon hi edge", 2'b10, 2'b00, 2'd2, 64'h0000_7FFF_FFFF_FFFF, 0, 0, 4'd8, 0, 0, 0);
    send("R1 noncanon", 2'b10, 2'b01, 2'd0, 64'h0000_8000_0000_0000, 1, 1, 4'd2, 0, 32'hFFFF, 1);
    send("R1 canon neg", 2'b10, 2'b10, 2'd3, 64'hFFFF_8000_0000_0000, 1, 1, 4'd0, 0, 0, 0);
    send("R1 noncanon neg", 2'b10, 2'b00, 2'd0, 64'hFFFF_7FFF_FFFF_FFFF, 1, 1, 4'd2, 0, 0, 1);
    // R2 invalid descriptor, even stack / not present
    send("R2 invalid stack", 2'b01, 2'b00, 2'd0, 64'h10, 0, 0, 4'd2, 0, 32'hFFFF, 1);
    // R3 not present
    send("R3 np stack", 2'b01, 2'b00, 2'd0, 64'h10, 1, 0, 4'd2, 0, 32'hFFFF, 1);
    send("R3 np other", 2'b01, 2'b01, 2'd0, 64'h10, 1, 0, 4'd8, 0, 32'hFFFF, 0);
    // R4 / R5 rights
    send("R4 write ro", 2'b01, 2'b01, 2'd0, 64'h10, 1, 1, 4'd0, 0, 32'hFFFF, 1);
    send("R4 rmw rw", 2'b01, 2'b10, 2'd2, 64'h10, 1, 1, 4'd3, 0, 32'hFFFF, 0);
    send("R5 read exec", 2'b01, 2'b00, 2'd0, 64'h10, 1, 1, 4'd12, 0, 32'hFFFF, 0);
    send("R5 read exec-read", 2'b01, 2'b00, 2'd1, 64'h10, 1, 1, 4'd10, 0, 32'hFFFF, 0);
    // R6 expand-up limits
    send("R6 dword at top", 2'b01, 2'b00, 2'd2, 64'hFFFC, 1, 1, 4'd2, 0, 32'hFFFF, 0);
    send("R6 dword past top", 2'b01, 2'b01, 2'd2, 64'hFFFD, 1, 1, 4'd2, 0, 32'hFFFF, 1);
    send("R6 len over limit", 2'b01, 2'b00, 2'd1, 64'h0, 1, 1, 4'd0, 0, 32'h0, 0);
    send("R6 no wrap 4G", 2'b01, 2'b01, 2'd2, 64'hFFFF_FFFC, 1, 1, 4'd2, 1, 32'hFFFF_FFFF, 0);
    send("R6 qword at 4G", 2'b01, 2'b00, 2'd3, 64'hFFFF_FFF9, 1, 1, 4'd2, 1, 32'hFFFF_FFFF, 0);
    // R7 expand-down
    send("R7 at limit", 2'b01, 2'b01, 2'd0, 64'h0FFF, 1, 1, 4'd6, 0, 32'h0FFF, 0);
    send("R7 above limit", 2'b01, 2'b00, 2'd0, 64'h1000, 1, 1, 4'd4, 0, 32'h0FFF, 0);
    send("R7 word at 64K", 2'b01, 2'b01, 2'd1, 64'hFFFE, 1, 1, 4'd7, 0, 32'h0FFF, 1);
    send("R7 word over 64K", 2'b01, 2'b01, 2'd1, 64'hFFFF, 1, 1, 4'd7, 0, 32'h0FFF, 1);
    send("R7 beyond 64K", 2'b01, 2'b00, 2'd0, 64'h1_0000, 1, 1, 4'd5, 0, 32'h0FFF, 0);
    send("R7 big bound", 2'b01, 2'b00, 2'd0, 64'h1_0000, 1, 1, 4'd5, 1, 32'h0FFF, 0);
    // R8 real mode
    send("R8 stack over", 2'b00, 2'b00, 2'd1, 64'hFFFF, 0, 0, 4'd8, 0, 32'hFFFF, 1);
    send("R8 other over", 2'b00, 2'b01, 2'd1, 64'hFFFF, 0, 0, 4'd8, 0, 32'hFFFF, 0);
    send("R8 ignores desc", 2'b00, 2'b01, 2'd0, 64'h20, 0, 0, 4'd8, 0, 32'hFFFF, 0);
    send("R8 mode 3 as real", 2'b11, 2'b00, 2'd0, 64'h20, 0, 0, 4'd8, 0, 32'hFFFF, 0);
    // R9 hint rules at limit threshold
    send("R9 lim 6 no hint", 2'b01, 2'b00, 2'd0, 64'h0, 1, 1, 4'd2, 0, 32'd6, 0);
    send("R9 lim 7 hint", 2'b01, 2'b01, 2'd0, 64'h0, 1, 1, 4'd2, 0, 32'd7, 0);
    send("R9 real lim 3", 2'b00, 2'b00, 2'd2, 64'h0, 1, 1, 4'd2, 0, 32'd3, 0);

    // Sweep every type and kind with back-pressure (R4 R5 R9 R10).
    bp_on = 1'b1;
    for (int t = 0; t < 16; t++) begin
      for (int k = 0; k < 3; k++) begin
        send("R9 type/kind sweep", 2'b01, 2'(k), 2'd2, 64'h100, 1, 1, 4'(t),
             1'b0, 32'h0000_0800, 1'b0);
      end
    end
    bp_on = 1'b0;

    repeat (20) @(posedge clk);
    checks++;
    if (got != sent || sb.size() != 0) begin
      errors++;
      $display("FAIL R10 response count: got %0d exp %0d", got, sent);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule